// File: doc/BRIEF.md
# Predicate Define and Register Unit

This unit holds a small file of one-bit predicate registers and carries out predicate-define operations on it. Each define compares two integer operands with a selected relation. The define is itself guarded by a predicate read from the file. The result then drives up to two destination predicates. Each destination has its own update type, and that type decides one of three outcomes: force 1, force 0, or keep the old value. Several read ports let downstream logic look up the predicate that guards an instruction. A value of 1 means the instruction may commit its result, and 0 means it must be squashed.

Two define slots are accepted in every cycle. Each slot has a plain valid strobe. The unit never pushes back, so there is no ready signal: a slot whose valid is high in a clock cycle is consumed at that edge. Updates to the same register from both slots resolve in the same cycle. A collision between an unconditional write and an OR-style or AND-style action is reported on an error pin one cycle later.

Top module: `pred_define_unit`

## Requirements
- R1: The file has 32 registers, indexed 0 to 31. Out of reset, registers 1 to 31 hold 0. Register 0 always reads as 1. Every action aimed at register 0 is dropped, and it never raises the error flag.
- R2: The 4-bit relation code selects one comparison of operand A against operand B: 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned less-or-equal, 8 unsigned greater, 9 unsigned greater-or-equal. Codes 10 to 15 give the result false.
- R3: The 3-bit destination type is encoded as follows: 0 unconditional, 1 unconditional-inverted, 2 or, 3 or-inverted, 4 and, 5 and-inverted. Types 6 and 7 leave the destination untouched.
- R4: Unconditional types always write the destination. With guard 1, type 0 writes the result and type 1 writes its inverse. With guard 0, both write 0.
- R5: With guard 1, type 2 writes 1 when the result is 1, and type 3 writes 1 when the result is 0. In every other case the register keeps its value.
- R6: With guard 1, type 4 writes 0 when the result is 0, and type 5 writes 0 when the result is 1. In every other case the register keeps its value.
- R7: Any number of or-style actions that reach one register in the same cycle give the OR of their set actions. Any number of and-style actions give the AND of their clear actions.
- R8: Two kinds of collision raise the error flag, and the flag goes high in the cycle after the defines and lasts one cycle. The first is an unconditional write plus an or/and-style action on the same register: the unconditional value is stored. The second is a set action plus a clear action on the same register with no unconditional write: the register keeps its value.
- R9: A new predicate value shows on the read ports in the cycle after its define. Guards are read from the file as it stood before the cycle's defines, so a define cannot guard on a value written in the same cycle.
- R10: When several unconditional writes reach one register in one cycle, slot 1 wins over slot 0. Within a slot, destination 1 wins over destination 0.
- R11: A slot whose valid is low changes no register and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| def_valid_i | input | NSLOT | One strobe per define slot |
| def_op_i | input | NSLOT x 4 | Relation code per slot |
| def_src_a_i | input | NSLOT x W | Operand A per slot |
| def_src_b_i | input | NSLOT x W | Operand B per slot |
| def_guard_i | input | NSLOT x 5 | Guard register index per slot |
| def_dst0_i | input | NSLOT x 5 | First destination index per slot |
| def_type0_i | input | NSLOT x 3 | First destination type per slot |
| def_dst1_i | input | NSLOT x 5 | Second destination index per slot |
| def_type1_i | input | NSLOT x 3 | Second destination type per slot |
| chk_idx_i | input | NRD x 5 | Register index looked up per read port |
| chk_commit_o | output | NRD | Predicate value per read port (1 = commit) |
| conflict_o | output | 1 | Collision seen in the previous cycle |

## Verification
The embedded assertions check these properties in every cycle:
- Register 0 reads as 1 on every port.
- Each destination produces at most one of write, set or clear.
- A false guard never sets or clears.
- A false guard under an unconditional type always writes 0.
- A register that no action touches keeps its value.
- An unconditional write always lands.

Some behaviours only the bench scenarios can show, because they need the value that is expected and not just a consistent one:
- The signed and unsigned comparisons agree with the codes.
- The or/and combining across slots gives the right result.
- The priority among colliding unconditional writes is right.
- A guard sees the old value when the same cycle also writes it.
- The error flag comes on the right cycle.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

  localparam int OPW = 4;
  localparam int TYW = 3;

  typedef enum logic [OPW-1:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_LTS = 4'd2,
    REL_LES = 4'd3,
    REL_GTS = 4'd4,
    REL_GES = 4'd5,
    REL_LTU = 4'd6,
    REL_LEU = 4'd7,
    REL_GTU = 4'd8,
    REL_GEU = 4'd9
  } rel_e;

  typedef enum logic [TYW-1:0] {
    PT_UNC  = 3'd0,
    PT_UNCN = 3'd1,
    PT_OR   = 3'd2,
    PT_ORN  = 3'd3,
    PT_AND  = 3'd4,
    PT_ANDN = 3'd5,
    PT_NOP6 = 3'd6,
    PT_NOP7 = 3'd7
  } ptype_e;

  // Outcome for one destination: unconditional write, set to 1, clear to 0
  typedef struct packed {
    logic wr;
    logic val;
    logic set;
    logic clr;
  } pact_t;

endpackage

// File: rtl/pdu_compare.sv
module pdu_compare
  import pdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  output logic           res_o
);

  logic eq, lts, ltu;

  always_comb begin
    eq  = (a_i == b_i);
    lts = ($signed(a_i) < $signed(b_i));
    ltu = (a_i < b_i);
    unique case (op_i)
      REL_EQ:  res_o = eq;
      REL_NE:  res_o = !eq;
      REL_LTS: res_o = lts;
      REL_LES: res_o = lts || eq;
      REL_GTS: res_o = !(lts || eq);
      REL_GES: res_o = !lts;
      REL_LTU: res_o = ltu;
      REL_LEU: res_o = ltu || eq;
      REL_GTU: res_o = !(ltu || eq);
      REL_GEU: res_o = !ltu;
      default: res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pdu_action.sv
module pdu_action
  import pdu_pkg::*;
(
  input  logic           en_i,
  input  logic           guard_i,
  input  logic           res_i,
  input  logic [TYW-1:0] type_i,
  output pact_t          act_o
);

  always_comb begin
    act_o = '0;
    if (en_i) begin
      unique case (type_i)
        PT_UNC:  begin act_o.wr = 1'b1; act_o.val = guard_i & res_i;  end
        PT_UNCN: begin act_o.wr = 1'b1; act_o.val = guard_i & ~res_i; end
        PT_OR:   act_o.set = guard_i & res_i;
        PT_ORN:  act_o.set = guard_i & ~res_i;
        PT_AND:  act_o.clr = guard_i & ~res_i;
        PT_ANDN: act_o.clr = guard_i & res_i;
        default: act_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/pdu_regfile.sv
module pdu_regfile
  import pdu_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NDST = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pact_t [NDST-1:0]          act_i,
  input  logic  [NDST-1:0][IW-1:0]  dst_i,
  output logic  [NREG-1:0]          pred_o,
  output logic                      conflict_o
);

  logic [NREG-1:0] pred_q, pred_d;
  logic [NREG-1:0] touch, unc_hit, unc_val, clash;
  logic            conflict_q;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      logic ua, uv, s, c;
      ua = 1'b0; uv = 1'b0; s = 1'b0; c = 1'b0;
      // later destinations overwrite earlier ones: slot 1 over slot 0, dst1 over dst0
      for (int d = 0; d < NDST; d++) begin
        if (dst_i[d] == IW'(r)) begin
          if (act_i[d].wr) begin
            ua = 1'b1;
            uv = act_i[d].val;
          end
          s = s | act_i[d].set;
          c = c | act_i[d].clr;
        end
      end
      touch[r]   = (r != 0) && (ua || s || c);
      unc_hit[r] = (r != 0) && ua;
      unc_val[r] = uv;
      clash[r]   = (r != 0) && ((ua && (s || c)) || (s && c));
      if (r == 0)        pred_d[r] = 1'b1;
      else if (ua)       pred_d[r] = uv;
      else if (s && c)   pred_d[r] = pred_q[r];
      else if (s)        pred_d[r] = 1'b1;
      else if (c)        pred_d[r] = 1'b0;
      else               pred_d[r] = pred_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q     <= NREG'(1);
      conflict_q <= 1'b0;
    end else begin
      pred_q     <= pred_d;
      conflict_q <= |clash;
    end
  end

  assign pred_o     = pred_q;
  assign conflict_o = conflict_q;

  generate
    for (genvar d = 0; d < NDST; d++) begin : g_act_chk
      assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_i[d].wr, act_i[d].set, act_i[d].clr}));
    end
    for (genvar r = 1; r < NREG; r++) begin : g_reg_chk
      assert_untouched_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !touch[r] |=> $stable(pred_q[r]));
      assert_unc_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unc_hit[r] |=> (pred_q[r] == $past(unc_val[r])));
    end
  endgenerate

endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit
  import pdu_pkg::*;
#(
  parameter int W     = 32,
  parameter int NREG  = 32,
  parameter int NSLOT = 2,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREG),
  localparam int NDST = 2 * NSLOT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0]             def_valid_i,
  input  logic [NSLOT-1:0][OPW-1:0]    def_op_i,
  input  logic [NSLOT-1:0][W-1:0]      def_src_a_i,
  input  logic [NSLOT-1:0][W-1:0]      def_src_b_i,
  input  logic [NSLOT-1:0][IW-1:0]     def_guard_i,
  input  logic [NSLOT-1:0][IW-1:0]     def_dst0_i,
  input  logic [NSLOT-1:0][TYW-1:0]    def_type0_i,
  input  logic [NSLOT-1:0][IW-1:0]     def_dst1_i,
  input  logic [NSLOT-1:0][TYW-1:0]    def_type1_i,
  input  logic [NRD-1:0][IW-1:0]       chk_idx_i,
  output logic [NRD-1:0]               chk_commit_o,
  output logic                         conflict_o
);

  logic [NREG-1:0]          pred;
  logic [NSLOT-1:0]         res, guard;
  pact_t [NDST-1:0]         act;
  logic [NDST-1:0][IW-1:0]  dst;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign guard[s] = pred[def_guard_i[s]];

      pdu_compare #(.W(W)) u_cmp (
        .a_i   (def_src_a_i[s]),
        .b_i   (def_src_b_i[s]),
        .op_i  (def_op_i[s]),
        .res_o (res[s])
      );

      pdu_action u_act0 (
        .en_i    (def_valid_i[s]),
        .guard_i (guard[s]),
        .res_i   (res[s]),
        .type_i  (def_type0_i[s]),
        .act_o   (act[2*s])
      );

      pdu_action u_act1 (
        .en_i    (def_valid_i[s]),
        .guard_i (guard[s]),
        .res_i   (res[s]),
        .type_i  (def_type1_i[s]),
        .act_o   (act[2*s+1])
      );

      assign dst[2*s]   = def_dst0_i[s];
      assign dst[2*s+1] = def_dst1_i[s];

      assert_guard_off_no_or_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (def_valid_i[s] && !guard[s]) |->
          !(act[2*s].set || act[2*s].clr || act[2*s+1].set || act[2*s+1].clr));
      assert_guard_off_unc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (def_valid_i[s] && !guard[s] && (def_type0_i[s] <= PT_UNCN)) |->
          (act[2*s].wr && !act[2*s].val));
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign chk_commit_o[p] = pred[chk_idx_i[p]];
      assert_reg0_commits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_idx_i[p] == '0) |-> chk_commit_o[p]);
    end
  endgenerate

  pdu_regfile #(.NREG(NREG), .NDST(NDST)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act),
    .dst_i      (dst),
    .pred_o     (pred),
    .conflict_o (conflict_o)
  );

endmodule

// File: tb/sim_pred_define_unit.sv
module sim_pred_define_unit;
  localparam int PERIOD = 10;
  localparam int W = 32, NREG = 32, NS = 2, NR = 2, IW = 5;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rst_n;
  logic [NS-1:0]          def_valid_i;
  logic [NS-1:0][3:0]     def_op_i;
  logic [NS-1:0][W-1:0]   def_src_a_i, def_src_b_i;
  logic [NS-1:0][IW-1:0]  def_guard_i, def_dst0_i, def_dst1_i;
  logic [NS-1:0][2:0]     def_type0_i, def_type1_i;
  logic [NR-1:0][IW-1:0]  chk_idx_i;
  logic [NR-1:0]          chk_commit_o;
  logic                   conflict_o;

  pred_define_unit u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  bit model [NREG];

  function automatic bit rel(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) <= $signed(b);
      4: return $signed(a) >  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a <  b;
      7: return a <= b;
      8: return a >  b;
      9: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic got, logic exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic setdef(int sl, logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                        int g, int d0, int t0, int d1, int t1);
    def_valid_i[sl] = 1'b1;
    def_op_i[sl] = op; def_src_a_i[sl] = a; def_src_b_i[sl] = b;
    def_guard_i[sl] = IW'(g);
    def_dst0_i[sl] = IW'(d0); def_type0_i[sl] = 3'(t0);
    def_dst1_i[sl] = IW'(d1); def_type1_i[sl] = 3'(t1);
  endtask

  task automatic idle();
    def_valid_i = '0;
  endtask

  task automatic rd(int i0, int i1);
    chk_idx_i[0] = IW'(i0);
    chk_idx_i[1] = IW'(i1);
  endtask

  // one clock: model next state from current model, then compare outputs
  task automatic step(string tag);
    bit ua [NREG]; bit uv [NREG]; bit st [NREG]; bit cl [NREG];
    bit nerr;
    nerr = 0;
    for (int r = 0; r < NREG; r++) begin ua[r] = 0; uv[r] = 0; st[r] = 0; cl[r] = 0; end
    for (int s = 0; s < NS; s++) begin
      if (def_valid_i[s]) begin
        bit g, c;
        g = model[def_guard_i[s]];
        c = rel(def_op_i[s], def_src_a_i[s], def_src_b_i[s]);
        for (int k = 0; k < 2; k++) begin
          int d, t;
          d = (k == 0) ? int'(def_dst0_i[s]) : int'(def_dst1_i[s]);
          t = (k == 0) ? int'(def_type0_i[s]) : int'(def_type1_i[s]);
          case (t)
            0: begin ua[d] = 1; uv[d] = g & c;  end
            1: begin ua[d] = 1; uv[d] = g & !c; end
            2: if (g && c)  st[d] = 1;
            3: if (g && !c) st[d] = 1;
            4: if (g && !c) cl[d] = 1;
            5: if (g && c)  cl[d] = 1;
            default: ;
          endcase
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int r = 1; r < NREG; r++) begin
      if ((ua[r] && (st[r] || cl[r])) || (st[r] && cl[r])) nerr = 1;
      if (ua[r]) model[r] = uv[r];
      else if (st[r] && !cl[r]) model[r] = 1;
      else if (cl[r] && !st[r]) model[r] = 0;
    end
    #1;
    check(tag, conflict_o, nerr, "conflict flag");
    check(tag, chk_commit_o[0], model[chk_idx_i[0]], $sformatf("port0 reg%0d", chk_idx_i[0]));
    check(tag, chk_commit_o[1], model[chk_idx_i[1]], $sformatf("port1 reg%0d", chk_idx_i[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = (r == 0);
    rst_n = 1'b0;
    def_valid_i = '0; def_op_i = '0; def_src_a_i = '0; def_src_b_i = '0;
    def_guard_i = '0; def_dst0_i = '0; def_dst1_i = '0;
    def_type0_i = '0; def_type1_i = '0;
    chk_idx_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 5); #1;
    check("R1", chk_commit_o[0], 1'b1, "reg0 after reset");
    check("R1", chk_commit_o[1], 1'b0, "reg5 after reset");
    check("R1", conflict_o, 1'b0, "flag after reset");

    // R4 guard 1: eq true -> type0 writes 1, type1 writes 0
    idle(); setdef(0, 0, 5, 5, 0, 3, 0, 4, 1); rd(3, 4); step("R4");
    check("R4", chk_commit_o[0], 1'b1, "unc true");
    check("R4", chk_commit_o[1], 1'b0, "unc inverted");
    // R4 guard 0 (reg 9 = 0): both write 0
    idle(); setdef(0, 0, 5, 5, 9, 3, 0, 4, 1); rd(3, 4); step("R4");
    check("R4", chk_commit_o[0], 1'b0, "unc guard off");

    // R2 every relation code, negative vs positive and equal operands
    for (int op = 0; op < 16; op++) begin
      idle(); setdef(0, 4'(op), '1, 32'd1, 0, 10, 0, 20, 0); rd(10, 20); step("R2");
      idle(); setdef(0, 4'(op), 32'd7, 32'd7, 0, 10, 0, 20, 1); rd(10, 20); step("R2");
      idle(); setdef(0, 4'(op), 32'd2, 32'hFFFF_FFFE, 0, 10, 1, 20, 0); rd(10, 20); step("R2");
    end

    // R5 or-type
    idle(); setdef(0, 0, 1, 1, 0, 11, 2, 11, 6); rd(11, 0); step("R5");
    check("R5", chk_commit_o[0], 1'b1, "or set");
    idle(); setdef(0, 0, 1, 2, 0, 11, 2, 11, 6); rd(11, 0); step("R5");
    check("R5", chk_commit_o[0], 1'b1, "or false keeps");
    idle(); setdef(0, 0, 1, 2, 0, 19, 3, 19, 7); rd(19, 0); step("R5");
    check("R5", chk_commit_o[0], 1'b1, "or-inverted set");
    idle(); setdef(0, 0, 1, 1, 9, 21, 2, 21, 2); rd(21, 0); step("R5");
    check("R5", chk_commit_o[0], 1'b0, "or guard off keeps");

    // R6 and-type
    idle(); setdef(0, 0, 1, 1, 0, 11, 4, 11, 6); rd(11, 0); step("R6");
    check("R6", chk_commit_o[0], 1'b1, "and true keeps");
    idle(); setdef(0, 0, 1, 2, 0, 11, 4, 11, 6); rd(11, 0); step("R6");
    check("R6", chk_commit_o[0], 1'b0, "and clear");
    idle(); setdef(0, 0, 1, 1, 9, 19, 5, 19, 5); rd(19, 0); step("R6");
    check("R6", chk_commit_o[0], 1'b1, "and guard off keeps");
    idle(); setdef(0, 0, 1, 1, 0, 19, 5, 19, 6); rd(19, 0); step("R6");
    check("R6", chk_commit_o[0], 1'b0, "and-inverted clear");

    // R7 combining across slots
    idle(); setdef(0, 0, 1, 2, 0, 12, 2, 12, 2); setdef(1, 0, 3, 3, 0, 12, 2, 12, 6);
    rd(12, 0); step("R7");
    check("R7", chk_commit_o[0], 1'b1, "or of sets");
    check("R7", conflict_o, 1'b0, "no flag for or+or");
    idle(); setdef(0, 0, 1, 1, 0, 12, 4, 12, 4); setdef(1, 0, 3, 4, 0, 12, 4, 12, 6);
    rd(12, 0); step("R7");
    check("R7", chk_commit_o[0], 1'b0, "and of clears");

    // R8 collisions
    idle(); setdef(0, 0, 1, 2, 0, 13, 0, 13, 6); setdef(1, 0, 3, 3, 0, 13, 2, 13, 6);
    rd(13, 0); step("R8");
    check("R8", chk_commit_o[0], 1'b0, "unc wins over or");
    check("R8", conflict_o, 1'b1, "flag on unc+or");
    idle(); step("R8");
    check("R8", conflict_o, 1'b0, "flag one cycle only");
    idle(); setdef(0, 0, 1, 1, 0, 14, 2, 14, 6); setdef(1, 0, 1, 1, 0, 14, 5, 14, 6);
    rd(14, 0); step("R8");
    check("R8", chk_commit_o[0], 1'b0, "set+clear keeps");
    check("R8", conflict_o, 1'b1, "flag on set+clear");

    // R10 unconditional priority
    idle(); setdef(0, 0, 1, 1, 0, 15, 0, 15, 6); setdef(1, 0, 1, 2, 0, 15, 0, 15, 6);
    rd(15, 0); step("R10");
    check("R10", chk_commit_o[0], 1'b0, "slot1 wins");
    idle(); setdef(0, 0, 1, 1, 0, 16, 0, 16, 1); rd(16, 0); step("R10");
    check("R10", chk_commit_o[0], 1'b0, "dst1 wins");

    // R9 guard sees pre-cycle value
    idle(); setdef(0, 0, 1, 1, 0, 17, 0, 17, 6); setdef(1, 0, 1, 1, 17, 18, 0, 18, 6);
    rd(17, 18); step("R9");
    check("R9", chk_commit_o[0], 1'b1, "written next cycle");
    check("R9", chk_commit_o[1], 1'b0, "guard old value");
    idle(); setdef(1, 0, 1, 1, 17, 18, 0, 18, 6); rd(18, 0); step("R9");
    check("R9", chk_commit_o[0], 1'b1, "guard new value");

    // R11 valid low does nothing
    idle(); def_op_i[0] = 0; def_guard_i[0] = 0; def_dst0_i[0] = 18; def_type0_i[0] = 1;
    def_dst1_i[0] = 17; def_type1_i[0] = 4; rd(18, 17); step("R11");
    check("R11", chk_commit_o[0], 1'b1, "reg18 held");
    check("R11", chk_commit_o[1], 1'b1, "reg17 held");

    // R3 no-op types 6 and 7
    idle(); setdef(0, 0, 1, 1, 0, 17, 6, 18, 7); rd(17, 18); step("R3");
    check("R3", chk_commit_o[0], 1'b1, "type6 no effect");

    // R1 writes to reg0 dropped, no flag
    idle(); setdef(0, 1, 1, 1, 0, 0, 0, 0, 4); setdef(1, 0, 1, 1, 0, 0, 2, 0, 6);
    rd(0, 0); step("R1");
    check("R1", chk_commit_o[0], 1'b1, "reg0 stays 1");
    check("R1", conflict_o, 1'b0, "no flag on reg0");

    // R9 randomized against the cycle model
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < NS; s++) begin
        def_valid_i[s] = 1'($urandom_range(0, 7) != 0);
        def_op_i[s]    = 4'($urandom_range(0, 15));
        def_src_a_i[s] = 32'($urandom_range(0, 3)) - 32'd1;
        def_src_b_i[s] = 32'($urandom_range(0, 3)) - 32'd1;
        def_guard_i[s] = IW'($urandom_range(0, 7));
        def_dst0_i[s]  = IW'($urandom_range(0, 7));
        def_dst1_i[s]  = IW'($urandom_range(0, 7));
        def_type0_i[s] = 3'($urandom_range(0, 7));
        def_type1_i[s] = 3'($urandom_range(0, 7));
      end
      rd($urandom_range(0, 7), $urandom_range(0, 31));
      step("R9");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule